// File: doc/BRIEF.md
# SONET Line Maintenance-Signal Inserter

This block sits on the transmit side of an STS-3 framer, just ahead of the line interface. The outgoing byte stream passes through it with frame-start, row and column markers. It rewrites the line-overhead fields that carry maintenance information back to the far-end line terminal. A far-end defect indication goes into the low three bits of the first K2 byte. A far-end error count goes into the M1 byte. On software command, everything outside the section overhead is overwritten with all ones as a line alarm signal.

The defect indication is raised automatically whenever the companion receive processor flags loss of signal, loss of frame, incoming line alarm, signal degrade or signal failure. Once raised, it is held for a minimum number of frames. Software can also force it. The error byte carries the parity-error count that the receive side reported for the previous frame, clipped to 255, unless software forces a value. Every control, every defect flag and the pending error count are taken once per frame, on the frame-start byte. No frame ever mixes old and new overhead.

The defect-hold logic is a three-state machine. `RDI_IDLE` goes to `RDI_ON` on *onset* (defect seen at a boundary). `RDI_ON` stays in `RDI_ON` on *persist* (defect still present). `RDI_ON` goes to `RDI_HOLD` on *early clear* (defect gone, minimum not yet reached). `RDI_HOLD` goes back to `RDI_ON` on *recur*. `RDI_HOLD` stays in `RDI_HOLD` on *count* (still short of the minimum). Both `RDI_ON` and `RDI_HOLD` go to `RDI_IDLE` on *expire* (no defect and minimum reached).

Top module: `loh_maint_inserter`

## Requirements
- R1: When any of the five receive defect flags is high at a frame-start byte, bits [2:0] of the K2 byte of that frame are 3'b110. K2 is at row 4, column 2*N_STS, with rows and columns counted from 0. The five flags are loss of signal, loss of frame, incoming AIS-L, signal degrade and signal failure.
- R2: When `sw_rdi_force` is high at a frame-start byte, K2 bits [2:0] of that frame are 3'b110, whatever the defect flags are.
- R3: The M1 byte is at row 8, column 2*N_STS+2. It carries the last `b2_cnt` reported with `b2_vld` during the previous frame, saturated to 255. If no count was reported during that frame, it carries 0. A report made on the frame-start byte itself counts toward the following frame.
- R4: When `sw_rei_force` is high at a frame-start byte, that frame's M1 byte equals `sw_rei_val`, which overrides the reported count.
- R5: When `sw_ais` is high at a frame-start byte, every byte of that frame outside the section overhead becomes 8'hFF. The section overhead is rows 0 to 2, columns 0 to 3*N_STS-1. This includes K2 and M1. No defect flag causes this.
- R6: Once the automatic defect indication starts, it stays on for at least RDI_HOLD consecutive frames (default 20) counting the onset frame. It stays on for as long as a defect is present at each frame start.
- R7: The control inputs and the defect flags take effect only at a frame-start byte. A change in mid-frame leaves the rest of that frame unchanged.
- R8: Every other byte, and the frame, row and column markers, appear at the output one clock after input, unchanged. K2 bits [7:3] pass through. When no defect indication applies, K2 bits [2:0] carry the `sw_k2_lo` sampled at frame start.
- R9: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Outgoing stream byte |
| in_fs | input | 1 | High on the first byte of a frame (row 0, column 0) |
| in_row | input | 4 | Row of the current byte, 0 to 8 |
| in_col | input | COL_W | Column of the current byte, 0 to 90*N_STS-1 |
| rx_los | input | 1 | Receive loss of signal |
| rx_lof | input | 1 | Receive loss of frame |
| rx_ais | input | 1 | Receive line AIS detected |
| rx_sd | input | 1 | Receive signal degrade |
| rx_sf | input | 1 | Receive signal failure |
| b2_vld | input | 1 | Strobe for a B2 error count |
| b2_cnt | input | B2_W | B2 error count of the previous received frame |
| sw_rdi_force | input | 1 | Software force of the defect indication |
| sw_k2_lo | input | 3 | K2 bits [2:0] when no indication applies |
| sw_rei_force | input | 1 | Software override of M1 |
| sw_rei_val | input | 8 | M1 value under override |
| sw_ais | input | 1 | Software command for line AIS |
| out_byte | output | 8 | Processed byte, one clock late |
| out_fs | output | 1 | Delayed frame-start marker |
| out_row | output | 4 | Delayed row marker |
| out_col | output | COL_W | Delayed column marker |

## Verification
Two pairs of functions can collide in one frame. The first pair is the line alarm and the defect indication: both claim K2. The second pair is the line alarm and the error indication: both claim M1. The bench provokes the first collision by raising a receive defect and `sw_ais` at the same frame boundary. It provokes the second by posting a B2 count and forcing `sw_rei_force` during alarm frames. A behavioural model, built from frame indices and a pending count, predicts every output byte, and it must see 8'hFF in both positions. After the alarm is released, the model must see the K2 pattern return with the defect hold still running.

// File: rtl/loh_pkg.sv
package loh_pkg;

    typedef enum logic [1:0] {
        RDI_IDLE = 2'd0,
        RDI_ON   = 2'd1,
        RDI_HOLD = 2'd2
    } rdi_state_e;

    localparam logic [2:0] K2_RDI_CODE = 3'b110;
    localparam int         FRAME_ROWS  = 9;

endpackage

// File: rtl/loh_rdi_fsm.sv
module loh_rdi_fsm
    import loh_pkg::*;
#(
    parameter int HOLD_FRAMES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frm_tick,
    input  logic defect,
    output logic rdi_on
);

    localparam int              CNT_W   = $clog2(HOLD_FRAMES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLD_FRAMES);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    rdi_state_e       st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             cnt_done;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_done = (cnt >= CNT_MAX);
    assign cnt_inc  = cnt_done ? CNT_MAX : cnt + CNT_ONE;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= RDI_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        if (frm_tick) begin
            unique case (st)
                RDI_IDLE: begin
                    if (defect) begin          // onset
                        st_nx  = RDI_ON;
                        cnt_nx = CNT_ONE;
                    end
                end
                RDI_ON, RDI_HOLD: begin
                    if (defect) begin          // persist / recur
                        st_nx  = RDI_ON;
                        cnt_nx = cnt_inc;
                    end else if (cnt_done) begin // expire
                        st_nx  = RDI_IDLE;
                        cnt_nx = '0;
                    end else begin             // early clear / count
                        st_nx  = RDI_HOLD;
                        cnt_nx = cnt_inc;
                    end
                end
                default: begin
                    st_nx  = RDI_IDLE;
                    cnt_nx = '0;
                end
            endcase
        end
    end

    always_comb begin
        rdi_on = (st != RDI_IDLE);
    end

    AST_RDI_ONSET: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_tick && defect) |=> rdi_on);                              // R1

    AST_RDI_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdi_on) |-> ($past(cnt) == CNT_MAX));                     // R6

    AST_RDI_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_tick |=> $stable(rdi_on));                                 // R7

endmodule

// File: rtl/loh_frame_latch.sv
module loh_frame_latch #(
    parameter int B2_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frm_tick,
    input  logic            sw_ais,
    input  logic            sw_rdi_force,
    input  logic [2:0]      sw_k2_lo,
    input  logic            sw_rei_force,
    input  logic [7:0]      sw_rei_val,
    input  logic            b2_vld,
    input  logic [B2_W-1:0] b2_cnt,
    output logic            frm_ais,
    output logic            frm_rdi_sw,
    output logic [2:0]      frm_k2_lo,
    output logic [7:0]      frm_m1
);

    localparam logic [B2_W-1:0] SAT_LIM = B2_W'(255);

    logic [7:0] b2_sat;
    logic [7:0] pend;

    always_comb begin
        b2_sat = (b2_cnt > SAT_LIM) ? 8'hFF : b2_cnt[7:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_ais    <= 1'b0;
            frm_rdi_sw <= 1'b0;
            frm_k2_lo  <= '0;
            frm_m1     <= '0;
            pend       <= '0;
        end else if (frm_tick) begin
            frm_ais    <= sw_ais;
            frm_rdi_sw <= sw_rdi_force;
            frm_k2_lo  <= sw_k2_lo;
            frm_m1     <= sw_rei_force ? sw_rei_val : pend;
            pend       <= b2_vld ? b2_sat : 8'h00;
        end else if (b2_vld) begin
            pend       <= b2_sat;
        end
    end

    AST_REI_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_tick && sw_rei_force) |=> (frm_m1 == $past(sw_rei_val)));  // R4

    AST_AIS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        frm_tick |=> (frm_ais == $past(sw_ais)));                      // R5

    AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_tick |=> ($stable(frm_ais) && $stable(frm_m1) && $stable(frm_k2_lo))); // R7

endmodule

// File: rtl/loh_maint_inserter.sv
module loh_maint_inserter
    import loh_pkg::*;
#(
    parameter int N_STS     = 3,
    parameter int STS1_COLS = 90,
    parameter int RDI_HOLD  = 20,
    parameter int B2_W      = 16,
    localparam int COLS     = N_STS * STS1_COLS,
    localparam int COL_W    = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       in_byte,
    input  logic             in_fs,
    input  logic [3:0]       in_row,
    input  logic [COL_W-1:0] in_col,
    input  logic             rx_los,
    input  logic             rx_lof,
    input  logic             rx_ais,
    input  logic             rx_sd,
    input  logic             rx_sf,
    input  logic             b2_vld,
    input  logic [B2_W-1:0]  b2_cnt,
    input  logic             sw_rdi_force,
    input  logic [2:0]       sw_k2_lo,
    input  logic             sw_rei_force,
    input  logic [7:0]       sw_rei_val,
    input  logic             sw_ais,
    output logic [7:0]       out_byte,
    output logic             out_fs,
    output logic [3:0]       out_row,
    output logic [COL_W-1:0] out_col
);

    localparam logic [COL_W-1:0] TOH_COLS = COL_W'(3 * N_STS);
    localparam logic [COL_W-1:0] K2_COL   = COL_W'(2 * N_STS);
    localparam logic [COL_W-1:0] M1_COL   = COL_W'(2 * N_STS + 2);
    localparam logic [3:0]       SOH_ROWS = 4'd3;
    localparam logic [3:0]       K2_ROW   = 4'd4;
    localparam logic [3:0]       M1_ROW   = 4'(FRAME_ROWS - 1);

    logic       defect_any;
    logic       rdi_auto;
    logic       rdi_any;
    logic       frm_ais, frm_rdi_sw;
    logic [2:0] frm_k2_lo;
    logic [7:0] frm_m1;
    logic       is_soh, is_k2, is_m1;
    logic [7:0] byte_nx;

    assign defect_any = rx_los | rx_lof | rx_ais | rx_sd | rx_sf;

    loh_rdi_fsm #(
        .HOLD_FRAMES (RDI_HOLD)
    ) u_rdi (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_tick (in_fs),
        .defect   (defect_any),
        .rdi_on   (rdi_auto)
    );

    loh_frame_latch #(
        .B2_W (B2_W)
    ) u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .frm_tick     (in_fs),
        .sw_ais       (sw_ais),
        .sw_rdi_force (sw_rdi_force),
        .sw_k2_lo     (sw_k2_lo),
        .sw_rei_force (sw_rei_force),
        .sw_rei_val   (sw_rei_val),
        .b2_vld       (b2_vld),
        .b2_cnt       (b2_cnt),
        .frm_ais      (frm_ais),
        .frm_rdi_sw   (frm_rdi_sw),
        .frm_k2_lo    (frm_k2_lo),
        .frm_m1       (frm_m1)
    );

    assign rdi_any = rdi_auto | frm_rdi_sw;
    assign is_soh  = (in_row < SOH_ROWS) && (in_col < TOH_COLS);
    assign is_k2   = (in_row == K2_ROW) && (in_col == K2_COL);
    assign is_m1   = (in_row == M1_ROW) && (in_col == M1_COL);

    always_comb begin
        byte_nx = in_byte;
        if (frm_ais && !is_soh) begin
            byte_nx = 8'hFF;
        end else if (is_k2) begin
            byte_nx = {in_byte[7:3], rdi_any ? K2_RDI_CODE : frm_k2_lo};
        end else if (is_m1) begin
            byte_nx = frm_m1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_byte <= '0;
            out_fs   <= 1'b0;
            out_row  <= '0;
            out_col  <= '0;
        end else begin
            out_byte <= byte_nx;
            out_fs   <= in_fs;
            out_row  <= in_row;
            out_col  <= in_col;
        end
    end

    AST_AIS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_ais && !is_soh) |=> (out_byte == 8'hFF));                   // R5

    AST_K2_RDI_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (rdi_any && !frm_ais && is_k2) |=> (out_byte[2:0] == 3'b110));   // R1

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_ais && !is_k2 && !is_m1) |=> (out_byte == $past(in_byte))); // R8

    AST_MARK_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_fs == $past(in_fs)));                             // R8

endmodule

// File: tb/loh_maint_inserter_tb.sv
module loh_maint_inserter_tb;

    localparam int NSTS   = 3;
    localparam int S1COLS = 12;
    localparam int NCOL   = NSTS * S1COLS;
    localparam int FRAME  = 9 * NCOL;
    localparam int CW     = $clog2(NCOL);
    localparam int HOLD   = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    in_byte = '0;
    logic          in_fs = 1'b0;
    logic [3:0]    in_row = '0;
    logic [CW-1:0] in_col = '0;
    logic          rx_los = 0, rx_lof = 0, rx_ais = 0, rx_sd = 0, rx_sf = 0;
    logic          b2_vld = 0;
    logic [15:0]   b2_cnt = '0;
    logic          sw_rdi_force = 0;
    logic [2:0]    sw_k2_lo = '0;
    logic          sw_rei_force = 0;
    logic [7:0]    sw_rei_val = '0;
    logic          sw_ais = 0;
    logic [7:0]    out_byte;
    logic          out_fs;
    logic [3:0]    out_row;
    logic [CW-1:0] out_col;

    always #4 clk = ~clk;

    loh_maint_inserter #(
        .N_STS(NSTS), .STS1_COLS(S1COLS), .RDI_HOLD(HOLD), .B2_W(16)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_fs(in_fs),
        .in_row(in_row), .in_col(in_col), .rx_los(rx_los), .rx_lof(rx_lof),
        .rx_ais(rx_ais), .rx_sd(rx_sd), .rx_sf(rx_sf), .b2_vld(b2_vld),
        .b2_cnt(b2_cnt), .sw_rdi_force(sw_rdi_force), .sw_k2_lo(sw_k2_lo),
        .sw_rei_force(sw_rei_force), .sw_rei_val(sw_rei_val), .sw_ais(sw_ais),
        .out_byte(out_byte), .out_fs(out_fs), .out_row(out_row), .out_col(out_col)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    pos = 0;
    bit    started = 0;
    bit    done = 0;
    string cur_req = "R9";

    // behavioural model state
    int       m_fidx = 0, m_start = 0, m_pend = 0, m_m1 = 0;
    bit       m_auto = 0, m_sw_rdi = 0, m_ais = 0;
    int       m_k2lo = 0;
    logic [7:0]    e_byte = '0;
    logic          e_fs = 0;
    logic [3:0]    e_row = '0;
    logic [CW-1:0] e_col = '0;

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_fidx = 0; m_start = 0; m_pend = 0; m_m1 = 0;
            m_auto = 0; m_sw_rdi = 0; m_ais = 0; m_k2lo = 0;
            e_byte = '0; e_fs = 0; e_row = '0; e_col = '0;
        end else begin
            if (in_fs) begin
                bit dfx;
                m_fidx = m_fidx + 1;
                dfx = rx_los | rx_lof | rx_ais | rx_sd | rx_sf;
                if (dfx && !m_auto) m_start = m_fidx;
                m_auto   = dfx || (m_auto && (m_fidx - m_start < HOLD));
                m_sw_rdi = sw_rdi_force;
                m_ais    = sw_ais;
                m_k2lo   = sw_k2_lo;
                m_m1     = sw_rei_force ? int'(sw_rei_val) : (m_pend > 255 ? 255 : m_pend);
                m_pend   = b2_vld ? int'(b2_cnt) : 0;
            end else if (b2_vld) begin
                m_pend = int'(b2_cnt);
            end
            e_fs  = in_fs;
            e_row = in_row;
            e_col = in_col;
            if (m_ais && !(in_row < 3 && in_col < 3 * NSTS))
                e_byte = 8'hFF;
            else if (in_row == 4 && in_col == 2 * NSTS)
                e_byte = {in_byte[7:3], (m_auto || m_sw_rdi) ? 3'b110 : 3'(m_k2lo)};
            else if (in_row == 8 && in_col == 2 * NSTS + 2)
                e_byte = 8'(m_m1);
            else
                e_byte = in_byte;
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            n_cmp++;
            if (out_byte !== e_byte || out_fs !== e_fs || out_row !== e_row || out_col !== e_col) begin
                n_bad++;
                $display("FAIL %s: row %0d col %0d byte=%h fs=%b expected byte=%h fs=%b (exp row %0d col %0d)",
                         cur_req, out_row, out_col, out_byte, out_fs, e_byte, e_fs, e_row, e_col);
            end
        end
    end

    task automatic step();
        @(negedge clk);
        in_byte = 8'($urandom);
        in_fs   = (pos == 0);
        in_row  = 4'(pos / NCOL);
        in_col  = CW'(pos % NCOL);
        pos     = (pos + 1) % FRAME;
    endtask

    task automatic frames(input int n);
        repeat (n * FRAME) step();
    endtask

    task automatic finish_frame();
        while (pos != 0) step();
    endtask

    task automatic b2_pulse(input int v);
        b2_vld = 1'b1;
        b2_cnt = 16'(v);
        step();
        b2_vld = 1'b0;
    endtask

    task automatic set_defect(input int k, input bit v);
        case (k)
            0: rx_los = v;
            1: rx_lof = v;
            2: rx_ais = v;
            3: rx_sd  = v;
            default: rx_sf = v;
        endcase
    endtask

    initial begin
        cur_req = "R9";                 // reset: outputs zero
        repeat (6) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R8";                 // plain pass-through, K2 low bits from software
        sw_k2_lo = 3'b101;
        frames(2);

        for (int k = 0; k < 5; k++) begin
            cur_req = (k == 4) ? "R5" : "R1"; // a defect must never produce AIS fill
            set_defect(k, 1'b1);
            frames(1);
            set_defect(k, 1'b0);
            cur_req = "R6";             // hold for the minimum frame count
            frames(HOLD + 1);
        end

        cur_req = "R6";                 // defect longer than the hold, then clear
        rx_sd = 1'b1;
        frames(HOLD + 3);
        rx_sd = 1'b0;
        frames(2);

        cur_req = "R7";                 // mid-frame control changes
        repeat (FRAME / 2) step();
        sw_rdi_force = 1'b1; sw_k2_lo = 3'b011; sw_ais = 1'b1; rx_lof = 1'b1;
        finish_frame();
        sw_ais = 1'b0; rx_lof = 1'b0;
        frames(1);
        repeat (FRAME / 3) step();
        sw_rdi_force = 1'b0;
        finish_frame();
        frames(HOLD + 1);

        cur_req = "R2";                 // software force of the indication
        sw_rdi_force = 1'b1;
        frames(2);
        sw_rdi_force = 1'b0;
        frames(1);

        cur_req = "R3";                 // error count, saturation, empty frame, last wins
        repeat (100) step(); b2_pulse(5); finish_frame();
        repeat (50) step();  b2_pulse(300); finish_frame();
        frames(1);
        repeat (20) step(); b2_pulse(7); repeat (30) step(); b2_pulse(255); finish_frame();
        step(); b2_pulse(256); finish_frame();
        step(); b2_pulse(40); finish_frame();
        frames(2);

        cur_req = "R4";                 // software override of M1
        sw_rei_force = 1'b1; sw_rei_val = 8'hA5;
        repeat (60) step(); b2_pulse(3); finish_frame();
        sw_rei_val = 8'h00;
        repeat (60) step(); b2_pulse(9); finish_frame();
        sw_rei_force = 1'b0;
        frames(2);

        cur_req = "R5";                 // AIS collides with defect indication and error count
        sw_ais = 1'b1; rx_los = 1'b1; sw_rei_force = 1'b1; sw_rei_val = 8'h3C;
        repeat (40) step(); b2_pulse(17); finish_frame();
        sw_rei_force = 1'b0;
        repeat (40) step(); b2_pulse(18); finish_frame();
        sw_ais = 1'b0; rx_los = 1'b0;
        cur_req = "R6";
        frames(HOLD + 1);

        cur_req = "R9";                 // reset mid-frame clears outputs
        repeat (10) step();
        rst_n = 1'b0;
        repeat (4) step();
        rst_n = 1'b1;
        pos = 0;
        cur_req = "R8";
        frames(2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule